// File: doc/BRIEF.md
# Quad-wiper I2C register slave

This block is the serial front end of a four-channel digital trimmer. It sits on a two-wire host bus as a slave and gives the host access to three things: four wiper registers that set the trim positions, a sixteen-byte nonvolatile store (its first four bytes back the wipers), and eight read-only bytes of per-channel calibration data. The bus lines arrive already synchronised to `clk`. The slave pulls SDA low through `sda_oe`.

After its address, each write carries an instruction byte. The instruction either points at a register, with further bytes written to successive addresses, or it issues a one-byte quick command. A quick command can step a wiper, double or halve it, or copy a wiper to or from the store. A read returns bytes from the current pointer, so a random read is a pointer-setting write followed by a repeated START. A store write is followed by a programming interval, and during that interval the slave withholds its address acknowledge. A low `wp_n` freezes every register except for restores from the store.

Top module: `trim_i2c_slave`

## Requirements
- R1: The slave acknowledges only the 7-bit address whose upper five bits are 01011 and whose lower two bits equal `strap_addr`. Any other address is not acknowledged, and the slave then ignores the bus until the next START.
- R2: An instruction byte with bit 7 = 0 is a register access. Bit 5 = 1 selects the store and bit 5 = 0 selects the wipers. Bits 4..0 load the address pointer. Data bytes written at wiper addresses 0..3 set wiper 0..3.
- R3: In a wiper write, each data byte advances the pointer by one within an eight-address ring (0..7), and the pointer returns to 0 after 7. Bytes that land on addresses 4..7 are acknowledged and discarded.
- R4: Store addresses 0..15 are readable and writable. Store addresses 24..31 are read-only calibration bytes: address 24+2c holds channel c's sign-and-integer byte and address 25+2c holds its fraction byte, taken from byte (address-24) of parameter TOL. Writes to store addresses 16..31 have no effect, and reads of 16..23 return 0.
- R5: A read returns the byte at the pointer, and the pointer then advances by the same rule as a write. In the store space the pointer is a 5-bit counter, so it wraps from 31 to 0. A read continues while the master acknowledges and ends when the master does not.
- R6: A write that carries only the address and an instruction byte sets the pointer. A read that follows, after a repeated START or a STOP and a new START, begins at that pointer.
- R7: A transaction that wrote the store, or that issued a store command, starts a busy interval of NV_WR_CYCLES clocks at its STOP. During the interval the slave does not acknowledge its own address. After the interval the slave acknowledges again.
- R8: While `wp_n` is low, register-access writes, store commands and step, double and halve commands have no effect. Reads and the restore commands (codes 1 and 7) work as usual.
- R9: An instruction byte with bit 7 = 1 is a quick command: code = bits 6..3 and channel = bits 1..0. The codes are: 1 restores the channel from the store; 2 saves the channel to the store; 3 halves the channel (shift right); 4 halves all channels; 5 decrements the channel, stopping at 0; 6 decrements all channels; 7 restores all channels; 8 doubles the channel, saturating at full scale; 9 doubles all channels; 10 increments the channel, saturating; 11 increments all channels. Code 0 has no effect.
- R10: A third byte after a quick command is acknowledged and ignored. Codes 12..15 are acknowledged but have no effect, and so are single-channel codes whose bit 2 is 1.
- R11: A STOP or a START at any bit position releases SDA, returns the framer to waiting for an address, and leaves every register unchanged by the unfinished byte.
- R12: After reset, every wiper holds midscale (2^(W-1)), every store byte holds NV_INIT, and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_addr | input | 2 | Low two bits of the slave address |
| wp_n | input | 1 | Write enable; low freezes registers |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| sda_oe | output | 1 | High pulls SDA low |
| wiper_flat | output | 4*W | Wiper c at bits c*W +: W |

## Verification
The embedded assertions check four things on every cycle. SDA drive changes only while SCL is low, unless a START or STOP forces a release. A STOP always releases the bus. The framer stays idle for the whole busy interval. A write-data byte cannot move a wiper while `wp_n` is low.

The arithmetic of every quick-command code on every channel field is shown only by the bench's scenarios, using saturating boundary values. The same holds for:
- the eight-address wiper ring and the 5-bit store-pointer wrap;
- the order of the calibration bytes;
- busy polling, where the bench sees at least one refused address and then an acknowledge;
- aborted bytes, which must leave the registers untouched.

// File: rtl/trim_i2c_slave.sv
module trim_i2c_slave #(
  parameter int W = 8,
  parameter int NV_WR_CYCLES = 2000,
  parameter logic [7:0] NV_INIT = 8'h80,
  parameter logic [63:0] TOL = 64'h0F1C_8207_0040_9512
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     strap_addr,
  input  logic           wp_n,
  input  logic           scl_i,
  input  logic           sda_i,
  output logic           sda_oe,
  output logic [4*W-1:0] wiper_flat
);
  localparam int NCH = 4;
  localparam int NNV = 16;
  localparam int BW = $clog2(NV_WR_CYCLES + 1);
  localparam logic [W-1:0] MID = W'(1) << (W - 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_INS, S_WD, S_QX, S_RD, S_SKIP} st_t;

  st_t st;
  logic scl_q, sda_q, ackph, oe, ptr_nv, pend;
  logic [3:0] bc;
  logic [7:0] sh, rbuf, rd_byte;
  logic [4:0] ptr, ptr_nx;
  logic [BW-1:0] busy;
  logic [W-1:0] wip [NCH];
  logic [W-1:0] q_w [NCH];
  logic [7:0] nv [NNV];
  logic [NCH-1:0] q_st, hit;

  wire rise_c  = scl_i & ~scl_q;
  wire fall_c  = ~scl_i & scl_q;
  wire start_c = scl_i & scl_q & sda_q & ~sda_i;
  wire stop_c  = scl_i & scl_q & ~sda_q & sda_i;

  assign sda_oe = oe;
  assign ptr_nx = ptr_nv ? ptr + 5'd1 : {2'b00, ptr[2:0] + 3'd1};

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign wiper_flat[g*W +: W] = wip[g];
  end

  function automatic logic [W-1:0] f_dbl(input logic [W-1:0] v);
    return v[W-1] ? {W{1'b1}} : {v[W-2:0], 1'b0};
  endfunction
  function automatic logic [W-1:0] f_inc(input logic [W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction
  function automatic logic [W-1:0] f_dec(input logic [W-1:0] v);
    return (|v) ? v - 1'b1 : v;
  endfunction

  always_comb begin
    rd_byte = 8'h00;
    if (!ptr_nv) begin
      if (ptr[4:2] == 3'b000) rd_byte = 8'(wip[ptr[1:0]]);
    end else if (!ptr[4]) rd_byte = nv[ptr[3:0]];
    else if (ptr[3]) rd_byte = TOL[8*ptr[2:0] +: 8];
  end

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      hit[i]  = !sh[2] && (sh[1:0] == 2'(i));
      q_w[i]  = wip[i];
      q_st[i] = 1'b0;
      case (sh[6:3])
        4'd1:  if (hit[i]) q_w[i] = nv[i][W-1:0];
        4'd2:  q_st[i] = hit[i] && wp_n;
        4'd3:  if (hit[i] && wp_n) q_w[i] = wip[i] >> 1;
        4'd4:  if (wp_n) q_w[i] = wip[i] >> 1;
        4'd5:  if (hit[i] && wp_n) q_w[i] = f_dec(wip[i]);
        4'd6:  if (wp_n) q_w[i] = f_dec(wip[i]);
        4'd7:  q_w[i] = nv[i][W-1:0];
        4'd8:  if (hit[i] && wp_n) q_w[i] = f_dbl(wip[i]);
        4'd9:  if (wp_n) q_w[i] = f_dbl(wip[i]);
        4'd10: if (hit[i] && wp_n) q_w[i] = f_inc(wip[i]);
        4'd11: if (wp_n) q_w[i] = f_inc(wip[i]);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1; sda_q <= 1'b1; st <= S_IDLE; sh <= '0; bc <= '0;
      ackph <= 1'b0; oe <= 1'b0; ptr_nv <= 1'b0; ptr <= '0; rbuf <= '0;
      pend <= 1'b0; busy <= '0;
      for (int i = 0; i < NCH; i++) wip[i] <= MID;
      for (int k = 0; k < NNV; k++) nv[k] <= NV_INIT;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (busy != '0) busy <= busy - 1'b1;
      if (start_c) begin
        st <= S_ADDR; bc <= '0; ackph <= 1'b0; oe <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE; bc <= '0; ackph <= 1'b0; oe <= 1'b0;
        if (pend) begin
          busy <= BW'(NV_WR_CYCLES);
          pend <= 1'b0;
        end
      end else if (st != S_IDLE && st != S_SKIP) begin
        if (rise_c) begin
          if (!ackph) begin
            sh <= {sh[6:0], sda_i};
            bc <= bc + 4'd1;
          end else if (st == S_RD && sda_i) st <= S_SKIP;
        end else if (fall_c) begin
          if (ackph) begin
            ackph <= 1'b0;
            bc <= '0;
            rbuf <= rd_byte;
            oe <= (st == S_RD) ? ~rd_byte[7] : 1'b0;
          end else if (bc == 4'd8) begin
            ackph <= 1'b1;
            case (st)
              S_ADDR:
                if (sh[7:1] == {5'b01011, strap_addr} && busy == '0) begin
                  oe <= 1'b1;
                  st <= sh[0] ? S_RD : S_INS;
                end else st <= S_IDLE;
              S_INS: begin
                oe <= 1'b1;
                if (sh[7]) begin
                  st <= S_QX;
                  for (int i = 0; i < NCH; i++) begin
                    wip[i] <= q_w[i];
                    if (q_st[i]) begin
                      nv[i] <= 8'(wip[i]);
                      pend <= 1'b1;
                    end
                  end
                end else begin
                  st <= S_WD;
                  ptr_nv <= sh[5];
                  ptr <= sh[4:0];
                end
              end
              S_WD: begin
                oe <= 1'b1;
                ptr <= ptr_nx;
                if (wp_n) begin
                  if (!ptr_nv && ptr[4:2] == 3'b000) wip[ptr[1:0]] <= sh[W-1:0];
                  else if (ptr_nv && !ptr[4]) begin
                    nv[ptr[3:0]] <= sh;
                    pend <= 1'b1;
                  end
                end
              end
              S_QX: oe <= 1'b1;
              S_RD: begin
                oe <= 1'b0;
                ptr <= ptr_nx;
              end
              default: oe <= 1'b0;
            endcase
          end else if (st == S_RD) oe <= ~rbuf[3'd7 - bc[2:0]];
        end
      end
    end
  end

  p_sda_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe) |-> (!$past(scl_i) || $past(start_c) || $past(stop_c)));

  p_stop_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (!sda_oe && st == S_IDLE));

  p_busy_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy != '0) |-> (st == S_IDLE || st == S_ADDR));

  p_wp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n && st == S_WD) |=> $stable(wiper_flat));
endmodule

// File: tb/test_trim_i2c_slave.sv
module test_trim_i2c_slave;
  localparam int W = 8;
  localparam int NVW = 400;
  localparam logic [7:0] NVI = 8'h80;
  localparam logic [63:0] TOLP = 64'h0F1C_8207_0040_9512;
  localparam logic [1:0] STRAP = 2'b10;
  localparam logic [7:0] AW = {5'b01011, STRAP, 1'b0};
  localparam logic [7:0] AR = {5'b01011, STRAP, 1'b1};

  logic clk = 0, rst_n = 0, wp_n = 1, scl_m = 1, sda_m = 1;
  logic sda_oe;
  logic [4*W-1:0] wiper_flat;
  wire sda_bus = sda_m & ~sda_oe;
  int errs = 0, checks = 0;
  logic [7:0] ew [4];
  logic [7:0] env [16];
  logic [7:0] dbuf [12];
  logic [7:0] rbuf [12];

  always #2 clk = ~clk;

  trim_i2c_slave #(.W(W), .NV_WR_CYCLES(NVW), .NV_INIT(NVI), .TOL(TOLP)) i_trim_i2c_slave (
    .clk(clk), .rst_n(rst_n), .strap_addr(STRAP), .wp_n(wp_n),
    .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe), .wiper_flat(wiper_flat));

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic q(); repeat (2) @(negedge clk); endtask
  task automatic i_start(); sda_m = 1; q(); scl_m = 1; q(); sda_m = 0; q(); scl_m = 0; q(); endtask
  task automatic i_stop(); sda_m = 0; q(); scl_m = 1; q(); sda_m = 1; q(); endtask

  task automatic sendbits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; q(); scl_m = 1; q(); q(); scl_m = 0;
    end
  endtask

  task automatic sendb(input logic [7:0] b, output logic ack);
    sendbits(b, 8);
    sda_m = 1; q(); scl_m = 1; q(); ack = ~sda_bus; q(); scl_m = 0; q();
  endtask

  task automatic recvb(output logic [7:0] b, input logic mack);
    sda_m = 1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      q(); scl_m = 1; q(); b = {b[6:0], sda_bus}; q(); scl_m = 0;
    end
    sda_m = ~mack; q(); scl_m = 1; q(); q(); scl_m = 0; q(); sda_m = 1;
  endtask

  task automatic wr(input logic [7:0] instr, input int n);
    logic a;
    i_start(); sendb(AW, a); sendb(instr, a);
    for (int i = 0; i < n; i++) sendb(dbuf[i], a);
    i_stop();
  endtask

  task automatic rd(input logic [7:0] instr, input int n);
    logic a;
    i_start(); sendb(AW, a); sendb(instr, a);
    i_start(); sendb(AR, a);
    for (int i = 0; i < n; i++) recvb(rbuf[i], i != n - 1);
    i_stop();
  endtask

  task automatic qcmd(input logic [3:0] c, input logic [2:0] ch);
    logic a;
    i_start(); sendb(AW, a); sendb({1'b1, c, ch}, a); i_stop();
  endtask

  task automatic poll(output int nacks);
    logic a;
    nacks = 0;
    for (int i = 0; i < 40; i++) begin
      i_start(); sendb(AW, a); i_stop();
      if (a) break;
      nacks++;
    end
  endtask

  task automatic chk_w(input string r);
    chk(r, wiper_flat, {ew[3], ew[2], ew[1], ew[0]});
  endtask

  function automatic logic [7:0] m_op(input logic [3:0] c, input logic [7:0] v);
    case (c)
      4'd3, 4'd4:   return v / 2;
      4'd5, 4'd6:   return (v == 0) ? 8'd0 : v - 8'd1;
      4'd8, 4'd9:   return (v >= 8'd128) ? 8'd255 : v * 2;
      4'd10, 4'd11: return (v == 8'd255) ? 8'd255 : v + 8'd1;
      default:      return v;
    endcase
  endfunction

  function automatic logic [7:0] pat(input int k);
    case (k % 8)
      0: return 8'h00; 1: return 8'h01; 2: return 8'h7F; 3: return 8'h80;
      4: return 8'hC0; 5: return 8'hFE; 6: return 8'hFF; default: return 8'h55;
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic a;
    int nk;
    for (int i = 0; i < 4; i++) ew[i] = 8'h80;
    for (int k = 0; k < 16; k++) env[k] = NVI;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk_w("R12 reset wipers");
    chk("R12 sda released", sda_bus, 1);
    rd(8'h20 | 8'd3, 1);
    chk("R12 store init", rbuf[0], NVI);

    // R1 address match
    i_start(); sendb({5'b01011, ~STRAP, 1'b0}, a); i_stop();
    chk("R1 foreign strap nack", a, 0);
    i_start(); sendb({5'b01010, STRAP, 1'b0}, a); i_stop();
    chk("R1 wrong upper bits nack", a, 0);
    i_start(); sendb(AW, a); i_stop();
    chk("R1 own address ack", a, 1);

    // R2/R3 consecutive wiper write, eight-address ring
    for (int i = 0; i < 9; i++) dbuf[i] = 8'h10 + 8'(i);
    wr(8'h00, 9);
    ew[0] = 8'h18; ew[1] = 8'h11; ew[2] = 8'h12; ew[3] = 8'h13;
    chk_w("R3 ring wrap to wiper0");
    dbuf[0] = 8'hA2; dbuf[1] = 8'hA3; dbuf[2] = 8'hA4;
    wr(8'h02, 3);
    ew[2] = 8'hA2; ew[3] = 8'hA3;
    chk_w("R2 start at wiper2, addr4 discarded");

    // R6 pointer-only write then current read
    i_start(); sendb(AW, a); sendb(8'h01, a); i_stop();
    i_start(); sendb(AR, a);
    for (int i = 0; i < 3; i++) recvb(rbuf[i], i != 2);
    i_stop();
    chk("R6 current read w1", rbuf[0], ew[1]);
    chk("R6 current read w2", rbuf[1], ew[2]);
    chk("R5 current read w3", rbuf[2], ew[3]);

    // R4/R7 store write with busy polling
    dbuf[0] = 8'h3C; dbuf[1] = 8'hC3; dbuf[2] = 8'h99;
    wr(8'h20 | 8'd14, 3);
    env[14] = 8'h3C; env[15] = 8'hC3;
    poll(nk);
    chk("R7 first poll refused", nk > 0, 1);
    chk("R7 ack within polls", nk < 40, 1);
    rd(8'h20 | 8'd14, 3);
    chk("R4 store 14", rbuf[0], 8'h3C);
    chk("R4 store 15", rbuf[1], 8'hC3);
    chk("R4 reserved 16 reads 0", rbuf[2], 0);

    // R4/R5 calibration bytes and pointer wrap 31->0
    rd(8'h20 | 8'd24, 9);
    for (int k = 0; k < 8; k++) chk("R4 calibration byte", rbuf[k], TOLP[8*k +: 8]);
    chk("R5 store pointer wraps to 0", rbuf[8], env[0]);
    dbuf[0] = 8'h00;
    wr(8'h20 | 8'd24, 1);
    i_start(); sendb(AW, a); i_stop();
    chk("R4 calibration write starts no busy", a, 1);
    rd(8'h20 | 8'd24, 1);
    chk("R4 calibration read-only", rbuf[0], TOLP[7:0]);

    // R9/R10 sweep over all codes and channel fields
    for (int c = 0; c < 16; c++) begin
      for (int ch = 0; ch < 8; ch++) begin
        for (int i = 0; i < 4; i++) begin
          dbuf[i] = pat(c * 8 + ch + i * 3);
          ew[i] = dbuf[i];
        end
        wr(8'h00, 4);
        qcmd(4'(c), 3'(ch));
        for (int i = 0; i < 4; i++) begin
          logic h, all;
          h = (ch < 4) && (ch == i);
          all = (c == 4) || (c == 6) || (c == 7) || (c == 9) || (c == 11);
          if (c == 2 && h) env[i] = ew[i];
          else if (c == 1 && h) ew[i] = env[i];
          else if (c == 7) ew[i] = env[i];
          else if (h || all) ew[i] = m_op(4'(c), ew[i]);
        end
        chk_w($sformatf("R9 code %0d chan %0d", c, ch));
        if (c == 2 && ch < 4) poll(nk);
      end
    end
    rd(8'h20, 4);
    for (int i = 0; i < 4; i++) chk("R9 store command contents", rbuf[i], env[i]);

    // R10 third byte after a quick command
    i_start(); sendb(AW, a); sendb({1'b1, 4'd10, 3'd1}, a); sendb(8'hAB, a); i_stop();
    chk("R10 third byte acked", a, 1);
    ew[1] = m_op(4'd10, ew[1]);
    chk_w("R10 third byte ignored");

    // R8 write protect
    wp_n = 0;
    dbuf[0] = 8'h5A;
    wr(8'h00, 1);
    chk_w("R8 wiper write frozen");
    qcmd(4'd11, 3'd0);
    chk_w("R8 increment frozen");
    qcmd(4'd2, 3'd0);
    i_start(); sendb(AW, a); i_stop();
    chk("R8 store command gives no busy", a, 1);
    rd(8'h20, 1);
    chk("R8 store unchanged", rbuf[0], env[0]);
    qcmd(4'd7, 3'd0);
    for (int i = 0; i < 4; i++) ew[i] = env[i];
    chk_w("R8 restore all works");
    wp_n = 1;

    // R11 aborted bytes
    i_start(); sendb(AW, a); sendb(8'h00, a); sendbits(8'h33, 4); i_start(); i_stop();
    chk_w("R11 repeated start mid data");
    i_start(); sendbits(AW, 3); i_stop();
    rd(8'h00, 1);
    chk("R11 bus usable after abort", rbuf[0], ew[0]);
    chk("R11 sda released", sda_bus, 1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule